// File: doc/BRIEF.md
# Ring Melody Square-Wave Generator

This block drives the ringer buzzer of a telephone front end. It produces a square wave at one of eight fixed melody frequencies. Each frequency comes from counting ticks of a 1.79 MHz time base. That tick can arrive at the base rate, or at twice the base rate from a faster oscillator, in which case the block uses only every second tick. A 2-bit level code goes out alongside the tone and sets the gain of an external analog buzzer amplifier.

A command decoder outside this block presents decoded strobes. A tone write only stores the selected frequency. A ring-start strobe starts the tone using the stored frequency. A stop strobe lets the period in progress run to its end before the buzzer goes quiet. A frequency change made while ringing takes effect at the next period boundary. An external-melody mode lets a tone pin replace the internal square wave, so the host can play frequencies outside the built-in eight.

Top module: `ring_melody_gen`

## Requirements
- R1: After reset, buz_o and buz_en_o are 0, level_o is 3, and the stored tone is the one for code 000000.
- R2: Each half-period lasts H = round(BASE_HZ / (2·f)) time-base ticks, computed as (BASE_HZ + f) / (2·f) in integers. The eight tone codes map to frequencies as follows: 000000→822 Hz, 000001→744 Hz, 000010→1005 Hz, 000011→909 Hz, 001100→1187 Hz, 001101→1074 Hz, 001110→1451 Hz, 001111→1312 Hz. Each period starts with the high half.
- R3: A tone write (freq_wr) while idle only stores the code. buz_en_o rises on the clock edge that samples ring_start.
- R4: A tone write made while ringing leaves the current period unchanged. The new half-period applies from the next period start, which is the end of a low half.
- R5: level_wr loads level_sel into level_o on the next clock edge. The encoding is 0 = minimum step, 1 and 2 = intermediate steps, 3 = maximum step.
- R6: After ring_stop during ringing, the period in progress completes and buz_en_o falls at the end of its low half. If ringing started on edge E0 and stop arrives in the first period, buz_en_o is high for exactly 2·H clock cycles.
- R7: ring_stop while idle has no effect. A ring_start while ringing withdraws a pending stop.
- R8: A tone write whose code is not one of the eight tone codes is ignored, and the stored tone is kept.
- R9: While ringing with ext_mode = 1, buz_o equals ext_tone delayed by one clock.
- R10: With osc_halve = 1 only every second base_tick counts, so every half-period after the first lasts 2·H base ticks.
- R11: While buz_en_o is 0, buz_o is 0, whatever ext_mode and ext_tone do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_tick | input | 1 | Time-base tick enable |
| osc_halve | input | 1 | Count only every second tick (fast oscillator) |
| freq_wr | input | 1 | Tone code write strobe |
| freq_code | input | 6 | Tone code |
| level_wr | input | 1 | Level write strobe |
| level_sel | input | 2 | Level step, 0 = min … 3 = max |
| ring_start | input | 1 | Start ringing strobe |
| ring_stop | input | 1 | Stop request strobe (mute or speech) |
| ext_mode | input | 1 | External melody selects buzzer source |
| ext_tone | input | 1 | External melody input |
| buz_o | output | 1 | Buzzer square wave |
| buz_en_o | output | 1 | Buzzer enable (ringing) |
| level_o | output | 2 | Level code to the amplifier |

## Verification
The bench builds the block with BASE_HZ = 179000 and holds base_tick high on every cycle. This shrinks the half-periods to between 62 and 120 clocks, so every tone can be timed to the exact cycle, stopped and changed within a few thousand cycles. With osc_halve the same timings double, which checks the halving path against the same integer expectations. Stops placed in the high half, in the low half, while idle and before a restart cover each way a period can end.

// File: rtl/rm_pkg.sv
package rm_pkg;

    localparam int NUM_TONES = 8;

    // Tone frequency in Hz by internal index {code[3], code[1:0]}
    function automatic int tone_hz(input int idx);
        case (idx)
            0:       return 822;
            1:       return 744;
            2:       return 1005;
            3:       return 909;
            4:       return 1187;
            5:       return 1074;
            6:       return 1451;
            default: return 1312;
        endcase
    endfunction

    // Half-period in time-base ticks, rounded to nearest
    function automatic int half_count(input int base_hz, input int idx);
        int f;
        f = tone_hz(idx);
        return (base_hz + f) / (2 * f);
    endfunction

    function automatic logic code_is_tone(input logic [5:0] c);
        return (c[5:4] == 2'b00) && (c[3] == c[2]);
    endfunction

    function automatic logic [2:0] code_to_idx(input logic [5:0] c);
        return {c[3], c[1:0]};
    endfunction

endpackage

// File: rtl/rm_tick_gate.sv
module rm_tick_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic base_tick,
    input  logic osc_halve,
    output logic tick_o
);
    logic tog_d, tog_q;

    always_comb begin
        tog_d = tog_q;
        if (base_tick && osc_halve) tog_d = ~tog_q;
        tick_o = base_tick && (!osc_halve || tog_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end
endmodule

// File: rtl/rm_cmd_regs.sv
module rm_cmd_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       freq_wr,
    input  logic [5:0] freq_code,
    input  logic       level_wr,
    input  logic [1:0] level_sel,
    output logic [2:0] freq_idx_o,
    output logic [1:0] level_o
);
    typedef struct packed {
        logic [2:0] idx;
        logic [1:0] lvl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (freq_wr && rm_pkg::code_is_tone(freq_code))
            r_d.idx = rm_pkg::code_to_idx(freq_code);
        if (level_wr)
            r_d.lvl = level_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{idx: 3'd0, lvl: 2'd3};
        else        r_q <= r_d;
    end

    assign freq_idx_o = r_q.idx;
    assign level_o    = r_q.lvl;
endmodule

// File: rtl/rm_tone_core.sv
module rm_tone_core #(
    parameter int BASE_HZ = 1790000,
    parameter int HALF_W  = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic       stop,
    input  logic [2:0] freq_idx,
    input  logic       ext_mode,
    input  logic       ext_tone,
    output logic       buz_o,
    output logic       buz_en_o
);
    typedef struct packed {
        logic              ring;
        logic              phase;
        logic              stop_pend;
        logic              ext;
        logic [HALF_W-1:0] cnt;
        logic [HALF_W-1:0] half;
    } core_t;

    logic [HALF_W-1:0] half_tbl [rm_pkg::NUM_TONES];

    for (genvar g = 0; g < rm_pkg::NUM_TONES; g++) begin : g_tbl
        assign half_tbl[g] = HALF_W'(rm_pkg::half_count(BASE_HZ, g));
    end

    core_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.ext = ext_tone;
        if (!s_q.ring) begin
            if (start) begin
                s_d.ring      = 1'b1;
                s_d.phase     = 1'b1;
                s_d.stop_pend = 1'b0;
                s_d.cnt       = '0;
                s_d.half      = half_tbl[freq_idx];
            end
        end else begin
            if (start)     s_d.stop_pend = 1'b0;
            else if (stop) s_d.stop_pend = 1'b1;
            if (tick) begin
                if (s_q.cnt == s_q.half - 1'b1) begin
                    s_d.cnt = '0;
                    if (s_q.phase) begin
                        s_d.phase = 1'b0;
                    end else if (s_d.stop_pend) begin
                        s_d.ring      = 1'b0;
                        s_d.stop_pend = 1'b0;
                    end else begin
                        s_d.phase = 1'b1;
                        s_d.half  = half_tbl[freq_idx];
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign buz_en_o = s_q.ring;
    assign buz_o    = s_q.ring && (ext_mode ? s_q.ext : s_q.phase);
endmodule

// File: rtl/ring_melody_gen.sv
module ring_melody_gen #(
    parameter int BASE_HZ = 1790000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_tick,
    input  logic       osc_halve,
    input  logic       freq_wr,
    input  logic [5:0] freq_code,
    input  logic       level_wr,
    input  logic [1:0] level_sel,
    input  logic       ring_start,
    input  logic       ring_stop,
    input  logic       ext_mode,
    input  logic       ext_tone,
    output logic       buz_o,
    output logic       buz_en_o,
    output logic [1:0] level_o
);
    localparam int MAX_HALF = rm_pkg::half_count(BASE_HZ, 1);
    localparam int HALF_W   = $clog2(MAX_HALF + 1);

    logic       tick;
    logic [2:0] freq_idx;

    rm_tick_gate u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .osc_halve (osc_halve),
        .tick_o    (tick)
    );

    rm_cmd_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .freq_wr    (freq_wr),
        .freq_code  (freq_code),
        .level_wr   (level_wr),
        .level_sel  (level_sel),
        .freq_idx_o (freq_idx),
        .level_o    (level_o)
    );

    rm_tone_core #(.BASE_HZ(BASE_HZ), .HALF_W(HALF_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (ring_start),
        .stop     (ring_stop),
        .freq_idx (freq_idx),
        .ext_mode (ext_mode),
        .ext_tone (ext_tone),
        .buz_o    (buz_o),
        .buz_en_o (buz_en_o)
    );
endmodule

// File: rtl/rm_ring_chk.sv
module rm_ring_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       freq_wr,
    input logic       ring_start,
    input logic       ring_stop,
    input logic       level_wr,
    input logic [1:0] level_sel,
    input logic       ext_mode,
    input logic       ext_tone,
    input logic       buz_o,
    input logic       buz_en_o,
    input logic [1:0] level_o
);
    // R11
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !buz_en_o |-> !buz_o);

    // R5
    level_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_wr |=> level_o == $past(level_sel));

    // R3
    store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !buz_en_o && freq_wr && !ring_start |=> !buz_en_o);

    // R7
    idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !buz_en_o && ring_stop && !ring_start |=> !buz_en_o);

    // R6
    end_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buz_en_o) && !$past(ext_mode) |-> !$past(buz_o));

    // R9
    ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buz_en_o && $past(buz_en_o) && ext_mode |-> buz_o == $past(ext_tone));
endmodule

bind ring_melody_gen rm_ring_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .freq_wr    (freq_wr),
    .ring_start (ring_start),
    .ring_stop  (ring_stop),
    .level_wr   (level_wr),
    .level_sel  (level_sel),
    .ext_mode   (ext_mode),
    .ext_tone   (ext_tone),
    .buz_o      (buz_o),
    .buz_en_o   (buz_en_o),
    .level_o    (level_o)
);

// File: tb/ring_melody_gen_tb_top.sv
module ring_melody_gen_tb_top;
    localparam int BASE = 179000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic base_tick = 1'b1, osc_halve = 1'b0;
    logic freq_wr = 1'b0, level_wr = 1'b0, ring_start = 1'b0, ring_stop = 1'b0;
    logic ext_mode = 1'b0, ext_tone = 1'b0;
    logic [5:0] freq_code = '0;
    logic [1:0] level_sel = '0;
    logic buz_o, buz_en_o;
    logic [1:0] level_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ring_melody_gen #(.BASE_HZ(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .osc_halve(osc_halve),
        .freq_wr(freq_wr), .freq_code(freq_code), .level_wr(level_wr),
        .level_sel(level_sel), .ring_start(ring_start), .ring_stop(ring_stop),
        .ext_mode(ext_mode), .ext_tone(ext_tone), .buz_o(buz_o),
        .buz_en_o(buz_en_o), .level_o(level_o)
    );

    function automatic int exp_half(input int i);
        int f;
        case (i)
            0: f = 822;   1: f = 744;   2: f = 1005;  3: f = 909;
            4: f = 1187;  5: f = 1074;  6: f = 1451;  default: f = 1312;
        endcase
        return (BASE + f) / (2 * f);
    endfunction

    function automatic logic [5:0] code_of(input int i);
        return {2'b00, i[2], i[2], i[1:0]};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_freq(input logic [5:0] c);
        @(negedge clk); freq_code = c; freq_wr = 1'b1;
        @(negedge clk); freq_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); ring_start = 1'b1;
        @(negedge clk); ring_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); ring_stop = 1'b1;
        @(negedge clk); ring_stop = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 5000 && buz_en_o; k++) @(negedge clk);
    endtask

    // count a high half then a low half, starting at the current negedge
    task automatic measure(output int hi, output int lo);
        hi = 0; lo = 0;
        while (buz_o && hi < 5000) begin hi++; @(negedge clk); end
        while (!buz_o && buz_en_o && lo < 5000) begin lo++; @(negedge clk); end
    endtask

    task automatic t_reset();
        check("R1 buz after reset", buz_o, 0);
        check("R1 en after reset", buz_en_o, 0);
        check("R1 level after reset", level_o, 3);
    endtask

    task automatic t_tones();
        int hi, lo;
        pulse_start();
        measure(hi, lo);
        check("R1 default tone high", hi, exp_half(0));
        check("R1 default tone low", lo, exp_half(0));
        pulse_stop(); wait_idle();
        for (int i = 0; i < 8; i++) begin
            wr_freq(code_of(i));
            pulse_start();
            measure(hi, lo);
            check($sformatf("R2 tone %0d high", i), hi, exp_half(i));
            check($sformatf("R2 tone %0d low", i), lo, exp_half(i));
            pulse_stop(); wait_idle();
        end
    endtask

    task automatic t_store_only();
        wr_freq(6'b001101);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (buz_en_o || buz_o) begin check("R3 idle after write", 1, 0); break; end
        end
        check("R3 stays idle", buz_en_o, 0);
        @(negedge clk); ring_start = 1'b1;
        @(negedge clk); ring_start = 1'b0;
        check("R3 en after start edge", buz_en_o, 1);
        pulse_stop(); wait_idle();
    endtask

    task automatic t_change_mid();
        int hi, lo, hi2, lo2;
        wr_freq(6'b000000);
        pulse_start();
        hi = 0;
        while (buz_o && hi < 5000) begin
            hi++;
            if (hi == 3) begin freq_code = 6'b001110; freq_wr = 1'b1; end
            if (hi == 4) freq_wr = 1'b0;
            @(negedge clk);
        end
        lo = 0;
        while (!buz_o && buz_en_o && lo < 5000) begin lo++; @(negedge clk); end
        check("R4 current high kept", hi, exp_half(0));
        check("R4 current low kept", lo, exp_half(0));
        measure(hi2, lo2);
        check("R4 next high new", hi2, exp_half(6));
        check("R4 next low new", lo2, exp_half(6));
        pulse_stop(); wait_idle();
    endtask

    task automatic t_level();
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); level_sel = 2'(v); level_wr = 1'b1;
            @(negedge clk); level_wr = 1'b0;
            check($sformatf("R5 level step %0d", v), level_o, v);
        end
    endtask

    task automatic run_count(input int stop_at, input int restart_at, output int n);
        n = 0;
        while (buz_en_o && n < 5000) begin
            n++;
            if (n == stop_at) ring_stop = 1'b1;
            if (n == stop_at + 1) ring_stop = 1'b0;
            if (n == restart_at) ring_start = 1'b1;
            if (n == restart_at + 1) ring_start = 1'b0;
            if (restart_at > 0 && n == 4 * exp_half(1)) break;
            @(negedge clk);
        end
    endtask

    task automatic t_stop();
        int n;
        wr_freq(6'b000001);
        pulse_start();
        run_count(10, -10, n);
        check("R6 stop in high half", n, 2 * exp_half(1));
        check("R6 buz low after stop", buz_o, 0);
        pulse_start();
        run_count(exp_half(1) + 10, -10, n);
        check("R6 stop in low half", n, 2 * exp_half(1));
        for (int k = 0; k < 10; k++) @(negedge clk);
        check("R6 remains idle", buz_en_o, 0);
    endtask

    task automatic t_idle_stop();
        int n;
        pulse_stop();
        for (int k = 0; k < 5; k++) @(negedge clk);
        check("R7 idle stop no effect", buz_en_o, 0);
        pulse_start();
        run_count(10, 20, n);
        check("R7 restart withdraws stop", buz_en_o, 1);
        pulse_stop(); wait_idle();
    endtask

    task automatic t_bad_code();
        int hi, lo;
        wr_freq(6'b001111);
        wr_freq(6'b000100);
        wr_freq(6'b010001);
        pulse_start();
        measure(hi, lo);
        check("R8 bad codes ignored", hi, exp_half(7));
        pulse_stop(); wait_idle();
    endtask

    task automatic t_ext();
        wr_freq(6'b000000);
        pulse_start();
        @(negedge clk); ext_mode = 1'b1; ext_tone = 1'b0;
        @(negedge clk);
        check("R9 ext low in high half", buz_o, 0);
        ext_tone = 1'b1;
        @(negedge clk);
        check("R9 ext high", buz_o, 1);
        ext_tone = 1'b0;
        @(negedge clk);
        check("R9 ext back low", buz_o, 0);
        ext_mode = 1'b0;
        pulse_stop(); wait_idle();
        ext_mode = 1'b1; ext_tone = 1'b1;
        for (int k = 0; k < 4; k++) @(negedge clk);
        check("R11 idle ignores ext", buz_o, 0);
        ext_mode = 1'b0; ext_tone = 1'b0;
        @(negedge clk);
        check("R11 idle low", buz_o, 0);
    endtask

    task automatic t_halve();
        int hi, lo;
        osc_halve = 1'b1;
        wr_freq(6'b000011);
        pulse_start();
        measure(hi, lo);
        check("R10 halved low half", lo, 2 * exp_half(3));
        measure(hi, lo);
        check("R10 halved high half", hi, 2 * exp_half(3));
        pulse_stop(); wait_idle();
        osc_halve = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        for (int k = 0; k < 150000 && !done; k++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tones();
        t_store_only();
        t_change_mid();
        t_level();
        t_stop();
        t_idle_stop();
        t_bad_code();
        t_ext();
        t_halve();
        done = 1'b1;
        report();
    end
endmodule